// File: doc/BRIEF.md
# Endpoint FIFO Space Allocator

This block carves contiguous regions out of a shared endpoint FIFO memory. Each fixed 512-byte unit of the memory is tracked by one bit of an occupancy map of up to 128 bits, so one allocator covers at most 64 KB. A chip places two copies of the block, one for transmit FIFO space and one for receive FIFO space. The two copies share no state.

An endpoint asks for space by giving its max packet size and a slot count. The block rounds the packet size up to a power of two to get the segment size. It multiplies the segment size by the slot count plus one to get the region size. It then searches the map from unit 0 upward for the lowest run of free units large enough to hold the region. When the run is found, the block marks it as used and returns the region's start address and size. When no run fits, it reports a failure and leaves the map as it was.

A release names a start address and a byte size. It frees the units that the region covers. The base address of the FIFO window and a limit on how many map bits may be used are configuration inputs.

Top module: `fifo_bitmap_alloc`

## Requirements
- R1: After synchronous reset, alloc_busy and alloc_done are low and every unit is free, so the first request of sufficient size is granted at cfg_base.
- R2: The granted size on alloc_size equals (alloc_slot + 1) times the max packet size rounded up to the next power of two. A packet size of 0 counts as 1.
- R3: A request occupies ceil(granted size / 512) units, so back-to-back grants pack tightly: each next grant starts right after the units the previous one used.
- R4: The grant takes the lowest-numbered run of free units long enough for the request. A free run that is too short is skipped, and space freed by a release is reused by a later request that fits it.
- R5: A successful grant reports alloc_addr = cfg_base + (first unit index) * 512.
- R6: When no free run fits within the usable units, alloc_ok is low while alloc_done is high, and the map is unchanged. The usable units are min(cfg_limit, 128) units counted from unit 0. This includes requests needing more than 128 units.
- R7: An accepted request (alloc_req high while alloc_busy is low) raises alloc_busy from the next cycle until alloc_done. alloc_done is a one-cycle pulse and comes no more than 130 cycles after acceptance. alloc_req is ignored while alloc_busy is high.
- R8: A release (rel_req for one cycle) clears the units from unit (rel_addr - cfg_base)/512 for ceil(rel_size/512) units. Clearing units that are already free has no effect on other units. A release with rel_addr below cfg_base is ignored.
- R9: With cfg_limit equal to 0, every request fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; frees every unit |
| cfg_base | input | 32 | Byte address of unit 0 of the FIFO window |
| cfg_limit | input | 8 | Number of map bits that may be used (values above 128 act as 128) |
| alloc_req | input | 1 | Allocation request, taken when alloc_busy is low |
| alloc_maxp | input | 16 | Endpoint max packet size in bytes |
| alloc_slot | input | 4 | Slot count; the region holds slot + 1 segments |
| alloc_busy | output | 1 | A search is in progress |
| alloc_done | output | 1 | One-cycle pulse: the result is valid |
| alloc_ok | output | 1 | With alloc_done: 1 means granted, 0 means failed |
| alloc_addr | output | 32 | Granted start byte address |
| alloc_size | output | 22 | Granted region size in bytes |
| rel_req | input | 1 | Release request, applied in the cycle it is high |
| rel_addr | input | 32 | Start byte address of the region to free |
| rel_size | input | 22 | Size in bytes of the region to free |

## Verification
The assertions take for granted that cfg_base and cfg_limit stay fixed while a search runs. They also assume that a release never targets the units being granted in the same cycle, so a grant always lands on units that were free and a failed search always leaves the map unchanged. The bench changes configuration only between requests, while the block is idle. It issues releases only between allocations, and each release names a region that was granted earlier or units that are known to be free. One release deliberately lies below the window base to show that it is dropped.

// File: rtl/fba_pkg.sv
package fba_pkg;

    localparam int UNIT_LG_DEF  = 9;
    localparam int MAP_BITS_DEF = 128;
    localparam int ADDR_W_DEF   = 32;
    localparam int MAXP_W_DEF   = 16;
    localparam int SLOT_W_DEF   = 4;

    typedef enum logic [1:0] {
        SC_IDLE   = 2'd0,
        SC_SCAN   = 2'd1,
        SC_REPORT = 2'd2
    } scan_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fba_sizer.sv
module fba_sizer #(
    parameter int MAXP_W   = fba_pkg::MAXP_W_DEF,
    parameter int SLOT_W   = fba_pkg::SLOT_W_DEF,
    parameter int UNIT_LG  = fba_pkg::UNIT_LG_DEF,
    parameter int MAP_BITS = fba_pkg::MAP_BITS_DEF,
    parameter int CNT_W    = $clog2(MAP_BITS + 2),
    parameter int REGION_W = MAXP_W + SLOT_W + 2
) (
    input  logic [MAXP_W-1:0]   maxp,
    input  logic [SLOT_W-1:0]   slot,
    output logic [REGION_W-1:0] region_bytes,
    output logic [CNT_W-1:0]    need_units
);
    localparam int SEG_W = MAXP_W + 1;
    localparam int SUM_W = REGION_W + 1;

    logic [SEG_W-1:0] seg;
    logic             seg_found;
    logic [SUM_W-1:0] units_full;

    // smallest power of two not below maxp
    always_comb begin
        seg       = '0;
        seg_found = 1'b0;
        for (int k = 0; k <= MAXP_W; k++) begin
            if (!seg_found && ((SEG_W'(1) << k) >= {1'b0, maxp})) begin
                seg       = SEG_W'(1) << k;
                seg_found = 1'b1;
            end
        end
    end

    always_comb begin
        region_bytes = REGION_W'(seg) * REGION_W'({1'b0, slot} + (SLOT_W + 1)'(1));
        units_full   = (SUM_W'(region_bytes) + SUM_W'((1 << UNIT_LG) - 1)) >> UNIT_LG;
        // saturate: anything past the map can never be placed
        if (units_full > SUM_W'(MAP_BITS))
            need_units = CNT_W'(MAP_BITS + 1);
        else
            need_units = CNT_W'(units_full);
    end

endmodule

// File: rtl/fba_range_mask.sv
module fba_range_mask #(
    parameter int MAP_BITS = fba_pkg::MAP_BITS_DEF,
    parameter int POS_W    = 7,
    parameter int CNT_W    = 8
) (
    input  logic                en,
    input  logic [POS_W-1:0]    first,
    input  logic [CNT_W-1:0]    count,
    output logic [MAP_BITS-1:0] mask
);
    localparam int SUM_W = fba_pkg::max3(POS_W, CNT_W, $clog2(MAP_BITS) + 1) + 1;

    logic [SUM_W-1:0] lo;
    logic [SUM_W-1:0] hi;

    assign lo = SUM_W'(first);
    assign hi = lo + SUM_W'(count);

    for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
        assign mask[i] = en && (lo <= SUM_W'(i)) && (SUM_W'(i) < hi);
    end

endmodule

// File: rtl/fba_scan.sv
module fba_scan #(
    parameter int MAP_BITS = fba_pkg::MAP_BITS_DEF,
    parameter int CNT_W    = $clog2(MAP_BITS + 2),
    parameter int IDX_W    = $clog2(MAP_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CNT_W-1:0]    need,
    input  logic [CNT_W-1:0]    limit,
    input  logic [MAP_BITS-1:0] map,
    output logic                busy,
    output logic                done,
    output logic                ok,
    output logic [IDX_W-1:0]    first_q,
    output logic [CNT_W-1:0]    need_q
);
    import fba_pkg::*;

    scan_state_e      state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] run;
    logic [CNT_W-1:0] lim_q;
    logic             ok_q;

    logic [CNT_W-1:0] lim_eff;
    logic             bit_free;
    logic [CNT_W-1:0] run_n;
    logic             hit;
    logic             last;
    logic [IDX_W-1:0] hit_first;

    always_comb begin
        lim_eff   = (limit > CNT_W'(MAP_BITS)) ? CNT_W'(MAP_BITS) : limit;
        bit_free  = !map[idx];
        run_n     = bit_free ? run + CNT_W'(1) : '0;
        hit       = bit_free && (run_n == need_q);
        last      = (CNT_W'(idx) == lim_q - CNT_W'(1));
        hit_first = IDX_W'(CNT_W'(idx) + CNT_W'(1) - need_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SC_IDLE;
            idx     <= '0;
            run     <= '0;
            need_q  <= '0;
            lim_q   <= '0;
            ok_q    <= 1'b0;
            first_q <= '0;
        end else begin
            case (state)
                SC_IDLE: if (start) begin
                    need_q  <= need;
                    lim_q   <= lim_eff;
                    idx     <= '0;
                    run     <= '0;
                    first_q <= '0;
                    ok_q    <= 1'b0;
                    if (lim_eff == '0 || need == '0 || need > lim_eff)
                        state <= SC_REPORT;
                    else
                        state <= SC_SCAN;
                end
                SC_SCAN: begin
                    run <= run_n;
                    if (hit) begin
                        ok_q    <= 1'b1;
                        first_q <= hit_first;
                        state   <= SC_REPORT;
                    end else if (last) begin
                        ok_q  <= 1'b0;
                        state <= SC_REPORT;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                SC_REPORT: state <= SC_IDLE;
                default:   state <= SC_IDLE;
            endcase
        end
    end

    assign busy = (state != SC_IDLE);
    assign done = (state == SC_REPORT);
    assign ok   = ok_q;

    // checks
    logic [CNT_W:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + (CNT_W + 1)'(1);
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_search_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= (CNT_W + 1)'(MAP_BITS + 1));

    p_grant_in_limit_r6: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> ((CNT_W + 1)'(first_q) + (CNT_W + 1)'(need_q) <= (CNT_W + 1)'(lim_q)));

endmodule

// File: rtl/fifo_bitmap_alloc.sv
module fifo_bitmap_alloc #(
    parameter int UNIT_LG  = fba_pkg::UNIT_LG_DEF,
    parameter int MAP_BITS = fba_pkg::MAP_BITS_DEF,
    parameter int ADDR_W   = fba_pkg::ADDR_W_DEF,
    parameter int MAXP_W   = fba_pkg::MAXP_W_DEF,
    parameter int SLOT_W   = fba_pkg::SLOT_W_DEF,
    localparam int CNT_W    = $clog2(MAP_BITS + 2),
    localparam int REGION_W = MAXP_W + SLOT_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [CNT_W-1:0]    cfg_limit,
    input  logic                alloc_req,
    input  logic [MAXP_W-1:0]   alloc_maxp,
    input  logic [SLOT_W-1:0]   alloc_slot,
    output logic                alloc_busy,
    output logic                alloc_done,
    output logic                alloc_ok,
    output logic [ADDR_W-1:0]   alloc_addr,
    output logic [REGION_W-1:0] alloc_size,
    input  logic                rel_req,
    input  logic [ADDR_W-1:0]   rel_addr,
    input  logic [REGION_W-1:0] rel_size
);
    localparam int IDX_W  = $clog2(MAP_BITS);
    localparam int RCNT_W = REGION_W + 1;

    logic [MAP_BITS-1:0] occ_map;
    logic [REGION_W-1:0] region_bytes;
    logic [CNT_W-1:0]    need_units;
    logic [REGION_W-1:0] size_q;
    logic [IDX_W-1:0]    grant_first;
    logic [CNT_W-1:0]    grant_need;
    logic [MAP_BITS-1:0] grant_mask;
    logic [MAP_BITS-1:0] rel_mask;
    logic                rel_valid;
    logic [ADDR_W-1:0]   rel_first;
    logic [RCNT_W-1:0]   rel_count;

    fba_sizer #(
        .MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_LG(UNIT_LG),
        .MAP_BITS(MAP_BITS), .CNT_W(CNT_W), .REGION_W(REGION_W)
    ) u_sizer (
        .maxp(alloc_maxp), .slot(alloc_slot),
        .region_bytes(region_bytes), .need_units(need_units)
    );

    fba_scan #(
        .MAP_BITS(MAP_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_scan (
        .clk(clk), .rst(rst), .start(alloc_req), .need(need_units),
        .limit(cfg_limit), .map(occ_map), .busy(alloc_busy),
        .done(alloc_done), .ok(alloc_ok), .first_q(grant_first),
        .need_q(grant_need)
    );

    fba_range_mask #(
        .MAP_BITS(MAP_BITS), .POS_W(IDX_W), .CNT_W(CNT_W)
    ) u_grant_mask (
        .en(alloc_done && alloc_ok), .first(grant_first),
        .count(grant_need), .mask(grant_mask)
    );

    assign rel_valid = rel_req && (rel_addr >= cfg_base);
    assign rel_first = (rel_addr - cfg_base) >> UNIT_LG;
    assign rel_count = (RCNT_W'(rel_size) + RCNT_W'((1 << UNIT_LG) - 1)) >> UNIT_LG;

    fba_range_mask #(
        .MAP_BITS(MAP_BITS), .POS_W(ADDR_W), .CNT_W(RCNT_W)
    ) u_rel_mask (
        .en(rel_valid), .first(rel_first), .count(rel_count), .mask(rel_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_map <= '0;
            size_q  <= '0;
        end else begin
            occ_map <= (occ_map | grant_mask) & ~rel_mask;
            if (alloc_req && !alloc_busy)
                size_q <= region_bytes;
        end
    end

    assign alloc_addr = cfg_base + (ADDR_W'(grant_first) << UNIT_LG);
    assign alloc_size = size_q;

    p_grant_was_free_r4: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && alloc_ok) |-> ((occ_map & grant_mask) == '0));

    p_fail_keeps_map_r6: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && !alloc_ok && !rel_req) |=> $stable(occ_map));

    p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
        rel_valid |=> ((occ_map & $past(rel_mask)) == '0));

    p_busy_until_done_r7: assert property (@(posedge clk) disable iff (rst)
        (alloc_busy && !alloc_done) |=> alloc_busy);

endmodule

// File: tb/fifo_bitmap_alloc_bench.sv
module fifo_bitmap_alloc_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_base;
    logic [7:0]  cfg_limit;
    logic        alloc_req;
    logic [15:0] alloc_maxp;
    logic [3:0]  alloc_slot;
    logic        alloc_busy;
    logic        alloc_done;
    logic        alloc_ok;
    logic [31:0] alloc_addr;
    logic [21:0] alloc_size;
    logic        rel_req;
    logic [31:0] rel_addr;
    logic [21:0] rel_size;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    localparam logic [31:0] BASE = 32'h1000;

    fifo_bitmap_alloc u_fifo_bitmap_alloc (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .alloc_req(alloc_req), .alloc_maxp(alloc_maxp), .alloc_slot(alloc_slot),
        .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_ok(alloc_ok),
        .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .rel_req(rel_req), .rel_addr(rel_addr), .rel_size(rel_size)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_alloc(input logic [15:0] maxp, input logic [3:0] slot,
                            output bit ok, output logic [31:0] addr,
                            output logic [21:0] size, output int lat);
        @(negedge clk);
        alloc_maxp = maxp;
        alloc_slot = slot;
        alloc_req  = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        lat = 1;
        while (!alloc_done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        ok   = alloc_ok;
        addr = alloc_addr;
        size = alloc_size;
    endtask

    task automatic do_release(input logic [31:0] addr, input logic [21:0] size);
        @(negedge clk);
        rel_addr = addr;
        rel_size = size;
        rel_req  = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
    endtask

    task automatic expect_grant(input string req, input logic [15:0] maxp,
                                input logic [3:0] slot, input logic [31:0] exp_addr,
                                input logic [21:0] exp_size);
        bit ok; logic [31:0] a; logic [21:0] s; int lat;
        do_alloc(maxp, slot, ok, a, s, lat);
        chk(ok == 1'b1, req, "grant ok", 64'(ok), 64'd1);
        chk(a == exp_addr, req, "grant addr", 64'(a), 64'(exp_addr));
        chk(s == exp_size, req, "grant size", 64'(s), 64'(exp_size));
    endtask

    task automatic expect_fail(input string req, input logic [15:0] maxp,
                               input logic [3:0] slot);
        bit ok; logic [31:0] a; logic [21:0] s; int lat;
        do_alloc(maxp, slot, ok, a, s, lat);
        chk(ok == 1'b0, req, "request fails", 64'(ok), 64'd0);
        chk(lat <= 130, req, "fail latency", 64'(lat), 64'd130);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk(alloc_busy == 1'b0, "R1", "busy after reset", 64'(alloc_busy), 64'd0);
        chk(alloc_done == 1'b0, "R1", "done after reset", 64'(alloc_done), 64'd0);
        expect_grant("R1", 16'd64, 4'd0, BASE, 22'd64);
    endtask

    // R2 R3 R4 R5 R8: packing, release, first fit
    task automatic t_pack_and_reuse();
        do_reset();
        expect_grant("R2", 16'd512, 4'd1, BASE, 22'd1024);               // units 0-1
        expect_grant("R3", 16'd1000, 4'd2, BASE + 32'h400, 22'd3072);    // units 2-7
        expect_grant("R5", 16'd64, 4'd1, BASE + 32'h1000, 22'd128);      // unit 8
        do_release(BASE, 22'd1024);                                      // frees 0-1
        expect_grant("R8", 16'd64, 4'd0, BASE, 22'd64);                  // unit 0
        expect_grant("R4", 16'd512, 4'd1, BASE + 32'h1200, 22'd1024);    // skips gap at 1, units 9-10
        expect_grant("R2", 16'd1, 4'd0, BASE + 32'h200, 22'd1);          // unit 1, size 1
        do_release(BASE + 32'h1600, 22'd1024);                           // units 11-12 already free
        do_release(32'h0, 22'h10000);                                    // below base: ignored
        expect_grant("R8", 16'd64, 4'd0, BASE + 32'h1600, 22'd64);       // unit 11
        expect_grant("R8", 16'd33, 4'd0, BASE + 32'h1800, 22'd64);       // unit 12
    endtask

    // R7: busy, done pulse, ignored request
    task automatic t_handshake();
        int lat;
        do_reset();
        @(negedge clk);
        alloc_maxp = 16'd512; alloc_slot = 4'd1; alloc_req = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        chk(alloc_busy == 1'b1, "R7", "busy after accept", 64'(alloc_busy), 64'd1);
        alloc_maxp = 16'd64; alloc_slot = 4'd0; alloc_req = 1'b1;        // while busy
        @(negedge clk);
        alloc_req = 1'b0;
        lat = 2;
        while (!alloc_done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(alloc_ok == 1'b1, "R7", "first request ok", 64'(alloc_ok), 64'd1);
        chk(alloc_addr == BASE, "R7", "first request addr", 64'(alloc_addr), 64'(BASE));
        chk(alloc_size == 22'd1024, "R7", "first request size", 64'(alloc_size), 64'd1024);
        @(negedge clk);
        chk(alloc_done == 1'b0, "R7", "done one cycle", 64'(alloc_done), 64'd0);
        repeat (4) @(negedge clk);
        chk(alloc_busy == 1'b0, "R7", "no second search", 64'(alloc_busy), 64'd0);
        expect_grant("R7", 16'd64, 4'd0, BASE + 32'h400, 22'd64);
    endtask

    // R6 R7: whole map in one grant, worst-case latency, then full
    task automatic t_full_map();
        bit ok; logic [31:0] a; logic [21:0] s; int lat;
        do_reset();
        do_alloc(16'd16384, 4'd3, ok, a, s, lat);
        chk(ok == 1'b1, "R6", "whole map grant", 64'(ok), 64'd1);
        chk(a == BASE, "R6", "whole map addr", 64'(a), 64'(BASE));
        chk(s == 22'd65536, "R2", "whole map size", 64'(s), 64'd65536);
        chk(lat <= 130, "R7", "worst latency", 64'(lat), 64'd130);
        expect_fail("R6", 16'd64, 4'd0);
    endtask

    // R6 R9: oversize, limit, zero limit
    task automatic t_limits();
        do_reset();
        expect_fail("R6", 16'hFFFF, 4'd15);                              // 2048 units
        expect_grant("R6", 16'd64, 4'd0, BASE, 22'd64);                  // map untouched
        do_reset();
        @(negedge clk);
        cfg_limit = 8'd4;
        expect_grant("R6", 16'd512, 4'd1, BASE, 22'd1024);
        expect_grant("R6", 16'd512, 4'd1, BASE + 32'h400, 22'd1024);
        expect_fail("R6", 16'd64, 4'd0);
        @(negedge clk);
        cfg_limit = 8'd128;
        expect_grant("R6", 16'd64, 4'd0, BASE + 32'h800, 22'd64);
        @(negedge clk);
        cfg_limit = 8'd0;
        expect_fail("R9", 16'd64, 4'd0);
        @(negedge clk);
        cfg_limit = 8'd128;
        expect_grant("R9", 16'd64, 4'd0, BASE + 32'hA00, 22'd64);
    endtask

    initial begin
        rst        = 1'b1;
        cfg_base   = BASE;
        cfg_limit  = 8'd128;
        alloc_req  = 1'b0;
        alloc_maxp = '0;
        alloc_slot = '0;
        rel_req    = 1'b0;
        rel_addr   = '0;
        rel_size   = '0;
        t_reset();
        t_pack_and_reuse();
        t_handshake();
        t_full_map();
        t_limits();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule